// File: doc/BRIEF.md
# Tagged byte/word addressable RAM

This block is a small data memory in which every word carries sixteen data bits and one extra tag bit. A single synchronous command port issues word reads, byte reads and tag updates. A separate word-write port loads the data bits. Data reads use byte addresses, and the word index is the byte address with its lowest bit dropped. The two bytes of a word therefore share one tag.

Tag updates come in two forms. One takes the word index directly. The other takes a byte address and acts on the word that byte belongs to. Every data read, word or byte, copies the addressed word's tag onto a status output. That output, like the read data, holds its value until the next read.

Top module: `tagged_ram`

## Requirements
- R1: While `rst_n` is low, `rd_data` is 0, `tag` is 0 and every word's tag is cleared. A read of any word after reset returns `tag` = 0 until a tag is set.
- R2: Command `cmd_op` = 3'd1 (word read) at byte address A returns the 16 data bits of word A>>1 on `rd_data` one clock after the command. A may be even or odd.
- R3: Command `cmd_op` = 3'd2 (byte read) at byte address A returns a byte of word A>>1 one clock later, zero-extended to 16 bits. An odd A gives bits [7:0] and an even A gives bits [15:8].
- R4: Every read, word or byte, puts the tag of word A>>1 on `tag` in the same cycle as `rd_data`. Byte addresses 2N and 2N+1 report the same tag.
- R5: Commands 3'd3 (set) and 3'd4 (clear) take a word index in `cmd_addr[AW-1:0]` and set or clear that word's tag.
- R6: Commands 3'd5 (set) and 3'd6 (clear) take a byte address A and set or clear the tag of word A>>1. This is the same bit that R5 reaches for word index A>>1.
- R7: Tag commands leave the data bits unchanged. Word writes (`wr_en` high, word index `wr_addr`, data `wr_data`) leave the tag unchanged. A write and a tag command on the same word in the same cycle both take effect.
- R8: Command 3'd0 (idle) and every tag command leave `rd_data` and `tag` unchanged.
- R9: A read and a write to the same word in the same cycle return the data held before the write. The next read returns the new data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 3 | Command code: 0 idle, 1 word read, 2 byte read, 3/4 set/clear tag by word index, 5/6 set/clear tag by byte address |
| cmd_addr | input | AW+1 | Byte address, or a word index in the low AW bits for codes 3 and 4 |
| wr_en | input | 1 | Word write enable |
| wr_addr | input | AW | Word index for the write |
| wr_data | input | 16 | Data written to the word |
| rd_data | output | 16 | Data of the last read |
| tag | output | 1 | Tag of the word touched by the last read |

## Verification
Read data and the tag appear on the first rising edge after the command, so the bench drives each command on a falling edge and samples at the next falling edge. A tag or data update takes effect on the edge that accepts it, and the bench observes it through a read issued afterwards, so the update shows up two edges after its command. The checks for held outputs after idle or tag commands sample at the same falling edge as a read would. The case of a read colliding with a write is sampled once for the old data and again one command later for the new data.

// File: rtl/tagged_ram.sv
module tagged_ram #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd_op,
  input  logic [AW:0]   cmd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [15:0]   wr_data,
  output logic [15:0]   rd_data,
  output logic          tag
);

  localparam logic [2:0] OP_RDW  = 3'd1;
  localparam logic [2:0] OP_RDB  = 3'd2;
  localparam logic [2:0] OP_SETW = 3'd3;
  localparam logic [2:0] OP_CLRW = 3'd4;
  localparam logic [2:0] OP_SETB = 3'd5;
  localparam logic [2:0] OP_CLRB = 3'd6;

  logic [15:0]      mem [DEPTH];
  logic [DEPTH-1:0] flags;

  wire [AW-1:0] byte_word = cmd_addr[AW:1];
  wire          word_form = (cmd_op == OP_SETW) || (cmd_op == OP_CLRW);
  wire          byte_form = (cmd_op == OP_SETB) || (cmd_op == OP_CLRB);
  wire          flag_wr   = word_form || byte_form;
  wire          flag_val  = (cmd_op == OP_SETW) || (cmd_op == OP_SETB);
  wire [AW-1:0] flag_idx  = word_form ? cmd_addr[AW-1:0] : byte_word;
  wire          is_read   = (cmd_op == OP_RDW) || (cmd_op == OP_RDB);

  wire [15:0] word_q = mem[byte_word];
  wire [7:0]  byte_q = cmd_addr[0] ? word_q[7:0] : word_q[15:8];
  wire [15:0] rd_next = (cmd_op == OP_RDB) ? {8'h00, byte_q} : word_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags <= '0;
    else if (flag_wr) flags[flag_idx] <= flag_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      tag     <= 1'b0;
    end else if (is_read) begin
      rd_data <= rd_next;
      tag     <= flags[byte_word];
    end
  end

endmodule

module tagged_ram_chk #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cmd_op,
  input logic [AW:0]      cmd_addr,
  input logic [15:0]      rd_data,
  input logic             tag,
  input logic [DEPTH-1:0] flags
);

  wire rd_any  = (cmd_op == 3'd1) || (cmd_op == 3'd2);
  wire flag_op = (cmd_op >= 3'd3) && (cmd_op <= 3'd6);

  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (flags == '0 && tag == 1'b0 && rd_data == 16'h0));

  assert_byte_zero_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == 3'd2 |=> rd_data[15:8] == 8'h00);

  assert_tag_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> tag == $past(flags[cmd_addr[AW:1]]));

  assert_word_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == 3'd3 |=> flags[$past(cmd_addr[AW-1:0])]);

  assert_word_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == 3'd4 |=> !flags[$past(cmd_addr[AW-1:0])]);

  assert_byte_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == 3'd5 |=> flags[$past(cmd_addr[AW:1])]);

  assert_byte_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_op == 3'd6 |=> !flags[$past(cmd_addr[AW:1])]);

  assert_flags_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_op |=> $stable(flags));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> ($stable(rd_data) && $stable(tag)));

endmodule

bind tagged_ram tagged_ram_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
  .rd_data(rd_data), .tag(tag), .flags(flags)
);

// File: tb/sim_tagged_ram.sv
`timescale 1ns/1ps
module sim_tagged_ram;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd_op = 3'd0;
  logic [AW:0]   cmd_addr = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic [15:0]   rd_data;
  logic          tag;

  logic [15:0] mdata [DEPTH];
  bit          mflag [DEPTH];
  logic [15:0] exp_rd;
  bit          exp_tag;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tagged_ram #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data(rd_data), .tag(tag)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input int addr);
    cmd_op = op;
    cmd_addr = addr[AW:0];
    @(posedge clk);
    @(negedge clk);
    cmd_op = 3'd0;
  endtask

  task automatic wr(input int w, input logic [15:0] d);
    wr_en = 1'b1;
    wr_addr = w[AW-1:0];
    wr_data = d;
    mdata[w] = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_word(input int a, input string req);
    cmd(3'd1, a);
    exp_rd = mdata[a >> 1];
    exp_tag = mflag[a >> 1];
    chk(rd_data, exp_rd, {req, " R2 data"});
    chk({15'h0, tag}, {15'h0, exp_tag}, {req, " R4 tag"});
  endtask

  task automatic read_byte(input int a, input string req);
    logic [15:0] d;
    cmd(3'd2, a);
    d = mdata[a >> 1];
    exp_rd = (a % 2 == 1) ? {8'h00, d[7:0]} : {8'h00, d[15:8]};
    exp_tag = mflag[a >> 1];
    chk(rd_data, exp_rd, {req, " R3 byte"});
    chk({15'h0, tag}, {15'h0, exp_tag}, {req, " R4 tag"});
  endtask

  task automatic flag_cmd(input logic [2:0] op, input int a);
    int w;
    w = (op == 3'd3 || op == 3'd4) ? a : (a >> 1);
    mflag[w] = (op == 3'd3 || op == 3'd5);
    cmd(op, a);
    chk(rd_data, exp_rd, "R8 rd_data held over tag command");
    chk({15'h0, tag}, {15'h0, exp_tag}, "R8 tag held over tag command");
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mdata[i] = 16'h0;
      mflag[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(rd_data, 16'h0, "R1 rd_data in reset");
    chk({15'h0, tag}, 16'h0, "R1 tag in reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < DEPTH; i++) begin
      cmd(3'd1, 2 * i + (i % 2));
      chk({15'h0, tag}, 16'h0, "R1 tag clear after reset");
    end

    for (int i = 0; i < DEPTH; i++) wr(i, 16'((i * 40503 + 4660) & 16'hFFFF));

    for (int i = 0; i < DEPTH; i++) begin
      read_word(2 * i + (i % 2), "sweep1");
      read_byte(2 * i, "sweep1 even");
      read_byte(2 * i + 1, "sweep1 odd");
    end

    for (int i = 0; i < DEPTH; i++) begin
      if (i % 3 == 0) flag_cmd(3'd3, i);
      if (i % 4 == 1) flag_cmd(3'd5, 2 * i + 1);
      if (i % 6 == 0 && i > 0) flag_cmd(3'd6, 2 * i);
      if (i % 7 == 3) begin
        flag_cmd(3'd3, i);
        flag_cmd(3'd4, i);
      end
      if (i % 10 == 7) flag_cmd(3'd5, 2 * i);
    end

    for (int i = 0; i < DEPTH; i += 2) wr(i, ~mdata[i] ^ 16'(i));

    for (int i = 0; i < DEPTH; i++) begin
      read_word(2 * i, "R5 R6 R7 sweep2");
      read_byte(2 * i, "R6 sweep2 even");
      read_byte(2 * i + 1, "R6 sweep2 odd");
    end

    cmd(3'd0, 0);
    chk(rd_data, exp_rd, "R8 rd_data held over idle");
    chk({15'h0, tag}, {15'h0, exp_tag}, "R8 tag held over idle");

    cmd_op = 3'd1;
    cmd_addr = 7'd18;
    wr_en = 1'b1;
    wr_addr = 6'd9;
    wr_data = 16'hBEEF;
    @(posedge clk);
    @(negedge clk);
    cmd_op = 3'd0;
    wr_en = 1'b0;
    chk(rd_data, mdata[9], "R9 collision returns old data");
    mdata[9] = 16'hBEEF;
    read_word(19, "R9 new data after collision");

    cmd_op = 3'd3;
    cmd_addr = 7'd10;
    wr_en = 1'b1;
    wr_addr = 6'd10;
    wr_data = 16'hC0DE;
    @(posedge clk);
    @(negedge clk);
    cmd_op = 3'd0;
    wr_en = 1'b0;
    mdata[10] = 16'hC0DE;
    mflag[10] = 1;
    read_word(20, "R7 write and tag set together");
    read_byte(21, "R7 write and tag set together");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule